// File: doc/BRIEF.md
# H-Bridge Current Chopping Controller

This block controls one motor winding through a four-switch H-bridge. Each leg has a high-side and a low-side gate enable. The controller drives current in the commanded direction until the digitized winding-current sample reaches a chopping threshold. It then holds a decay phase for a fixed off-time and returns to drive. The threshold is a fraction of a full-scale value chosen by a 2-bit scale code. The same value goes out on `thresh_out` so that an external reference DAC can use it.

Two decay behaviours are selectable. In fast decay the bridge switches to the opposite diagonal. A near-zero current detect can end that reverse conduction early, leaving all switches off. In slow decay both low-side switches recirculate the current. A blanking window after each entry into drive masks the comparison. A dead-time gap with every switch off separates any change of a leg from one side to the other.

States of the phase machine: IDLE (all off), DRIVE, FAST_REV (reverse diagonal), FAST_OFF (all off after near-zero) and SLOW (both low sides). The transitions are:
- IDLE→DRIVE when the bridge is run.
- DRIVE→FAST_REV or DRIVE→SLOW on a threshold crossing after blanking.
- FAST_REV→FAST_OFF on near-zero.
- FAST_REV, FAST_OFF or SLOW →DRIVE when the off-time counter expires.
- Any state →IDLE when `enable` is low or the scale code is 11.

Top module: `hbridge_chopper`

## Requirements
- R1: `thresh_out` equals `full_scale`×F/256, truncated, with F=256 for code 00, 182 for code 01, 97 for code 10 and 0 for code 11.
- R2: When `scale_code` is 11 or `enable` is low, all four gate outputs are 0 in that same cycle.
- R3: In drive, `dir`=1 turns on gate_ah and gate_bl, and `dir`=0 turns on gate_bh and gate_al. The output pattern {ah,al,bh,bl} is 1001 for `dir`=1 and 0110 for `dir`=0.
- R4: A chop occurs only when `i_sense` >= the scaled threshold. While `i_sense` stays below it, the drive pattern holds.
- R5: After each entry into DRIVE, the comparison is ignored at the first `blank_cycles` rising edges. The first chop can occur at edge `blank_cycles`+1.
- R6: Slow decay turns on gate_al and gate_bl only (pattern 0101). The two high-side gates are never on together.
- R7: Fast decay turns on the diagonal opposite to the drive direction that held at the crossing.
- R8: In fast reverse, `i_sense` <= `zero_level` moves the bridge to all off. It stays all off until the off-time expires.
- R9: A decay phase lasts `off_time`+1 cycles from the crossing edge, then the machine returns to DRIVE.
- R10: The two switches of a leg are never on together. When a leg changes side, all four gates are off for at least `dead_cycles`+1 cycles. The gap is exactly that long when it is the limiting delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Bridge run enable |
| dir | input | 1 | Commanded current direction |
| fast_decay | input | 1 | 1 selects fast decay, 0 slow decay |
| scale_code | input | 2 | Current scale code (00 full, 01, 10, 11 off) |
| i_sense | input | IW | Digitized winding current |
| full_scale | input | IW | Full-scale chopping current |
| zero_level | input | IW | Near-zero current level |
| off_time | input | OFF_W | Decay hold time in cycles minus one |
| blank_cycles | input | BLANK_W | Blanking length after drive entry |
| dead_cycles | input | DT_W | Dead-time length minus one |
| thresh_out | output | IW | Scaled threshold for the reference DAC |
| gate_ah | output | 1 | Leg A high-side enable |
| gate_al | output | 1 | Leg A low-side enable |
| gate_bh | output | 1 | Leg B high-side enable |
| gate_bl | output | 1 | Leg B low-side enable |

## Verification
Near-zero detection and the dead-time guard can overlap. The near-zero exit turns the reverse diagonal off and starts a dead-time count. The next drive then needs the opposite side of both legs, so the off-time expiry and the pending dead-time meet at the same edge. The bench provokes this by watching the gates and dropping `i_sense` below `zero_level` in the first cycle the reverse diagonal appears. The scoreboard judges it by the exact lengths of the reverse run (2 cycles) and the all-off run (5 cycles, set by the off-time rather than the 3-cycle dead-time). A second overlap is a threshold crossing while a drive pattern is still waiting out its dead-time. Blanking longer than the dead-time keeps that case ordered, and the drive-run lengths check it.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DRIVE,
        PH_FAST_REV,
        PH_FAST_OFF,
        PH_SLOW
    } phase_t;

    typedef struct packed {
        logic ah;
        logic al;
        logic bh;
        logic bl;
    } gates_t;

    localparam logic [1:0] CODE_OFF = 2'b11;

endpackage

// File: rtl/hb_scale.sv
module hb_scale #(
    parameter int IW = 10
) (
    input  logic [1:0]    code,
    input  logic [IW-1:0] full_scale,
    output logic [IW-1:0] thresh
);
    localparam int PW = IW + 9;

    logic [8:0]    factor;
    logic [PW-1:0] prod;

    always_comb begin
        unique case (code)
            2'b00: factor = 9'd256;
            2'b01: factor = 9'd182;
            2'b10: factor = 9'd97;
            2'b11: factor = 9'd0;
        endcase
    end

    assign prod   = {9'b0, full_scale} * {{IW{1'b0}}, factor};
    assign thresh = prod[IW+7:8];

endmodule

// File: rtl/hb_phase_fsm.sv
module hb_phase_fsm
    import hb_pkg::*;
#(
    parameter int IW      = 10,
    parameter int OFF_W   = 8,
    parameter int BLANK_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               dir,
    input  logic               fast_sel,
    input  logic [IW-1:0]      i_sense,
    input  logic [IW-1:0]      thresh,
    input  logic [IW-1:0]      zero_level,
    input  logic [OFF_W-1:0]   off_time,
    input  logic [BLANK_W-1:0] blank_cycles,
    output gates_t             want
);
    localparam logic [OFF_W-1:0]   OFF_ONE   = 1;
    localparam logic [BLANK_W-1:0] BLANK_ONE = 1;

    phase_t             st, nxt;
    logic [BLANK_W-1:0] blank_cnt;
    logic [OFF_W-1:0]   off_cnt;
    logic               dir_q;
    logic               in_decay;
    logic               crossing;

    assign in_decay = (st == PH_FAST_REV) || (st == PH_FAST_OFF) || (st == PH_SLOW);
    assign crossing = (blank_cnt == '0) && (i_sense >= thresh);

    // next-state selection
    always_comb begin
        nxt = st;
        if (!run) begin
            nxt = PH_IDLE;
        end else begin
            unique case (st)
                PH_IDLE:     nxt = PH_DRIVE;
                PH_DRIVE:    if (crossing) nxt = fast_sel ? PH_FAST_REV : PH_SLOW;
                PH_FAST_REV: begin
                    if (off_cnt == '0)              nxt = PH_DRIVE;
                    else if (i_sense <= zero_level) nxt = PH_FAST_OFF;
                end
                PH_FAST_OFF: if (off_cnt == '0) nxt = PH_DRIVE;
                PH_SLOW:     if (off_cnt == '0) nxt = PH_DRIVE;
            endcase
        end
    end

    // state register and phase counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= PH_IDLE;
            blank_cnt <= '0;
            off_cnt   <= '0;
            dir_q     <= 1'b0;
        end else begin
            st <= nxt;
            if (st == PH_DRIVE) dir_q <= dir;
            if (nxt == PH_DRIVE && st != PH_DRIVE)
                blank_cnt <= blank_cycles;
            else if (st == PH_DRIVE && blank_cnt != '0)
                blank_cnt <= blank_cnt - BLANK_ONE;
            if (st == PH_DRIVE && nxt != PH_DRIVE && nxt != PH_IDLE)
                off_cnt <= off_time;
            else if (in_decay && off_cnt != '0)
                off_cnt <= off_cnt - OFF_ONE;
        end
    end

    // requested switch pattern per phase
    always_comb begin
        want = '0;
        unique case (st)
            PH_IDLE, PH_FAST_OFF: want = '0;
            PH_DRIVE: begin
                if (dir) begin want.ah = 1'b1; want.bl = 1'b1; end
                else     begin want.bh = 1'b1; want.al = 1'b1; end
            end
            PH_FAST_REV: begin
                if (dir_q) begin want.bh = 1'b1; want.al = 1'b1; end
                else       begin want.ah = 1'b1; want.bl = 1'b1; end
            end
            PH_SLOW: begin
                want.al = 1'b1;
                want.bl = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
    import hb_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  gates_t          want,
    input  logic [DT_W-1:0] dead_cycles,
    output gates_t          gates
);
    localparam logic [DT_W-1:0] DT_ONE = 1;

    logic [DT_W-1:0] dt;
    logic            seen_a, hi_a, seen_b, hi_b;
    logic            on_clash, hist_clash, turning_off;

    assign on_clash = (gates.ah & want.al) | (gates.al & want.ah) |
                      (gates.bh & want.bl) | (gates.bl & want.bh);
    assign hist_clash = (seen_a & ((want.ah & ~hi_a) | (want.al & hi_a))) |
                        (seen_b & ((want.bh & ~hi_b) | (want.bl & hi_b)));
    assign turning_off = |(gates & ~want);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gates  <= '0;
            dt     <= '0;
            seen_a <= 1'b0;
            hi_a   <= 1'b0;
            seen_b <= 1'b0;
            hi_b   <= 1'b0;
        end else if (on_clash) begin
            gates <= '0;
            dt    <= dead_cycles;
        end else if (hist_clash && dt != '0) begin
            gates <= '0;
            dt    <= dt - DT_ONE;
        end else begin
            gates <= want;
            if (turning_off)    dt <= dead_cycles;
            else if (dt != '0)  dt <= dt - DT_ONE;
            if (want.ah)      begin seen_a <= 1'b1; hi_a <= 1'b1; end
            else if (want.al) begin seen_a <= 1'b1; hi_a <= 1'b0; end
            if (want.bh)      begin seen_b <= 1'b1; hi_b <= 1'b1; end
            else if (want.bl) begin seen_b <= 1'b1; hi_b <= 1'b0; end
        end
    end

endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
    import hb_pkg::*;
#(
    parameter int IW      = 10,
    parameter int OFF_W   = 8,
    parameter int DT_W    = 4,
    parameter int BLANK_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               dir,
    input  logic               fast_decay,
    input  logic [1:0]         scale_code,
    input  logic [IW-1:0]      i_sense,
    input  logic [IW-1:0]      full_scale,
    input  logic [IW-1:0]      zero_level,
    input  logic [OFF_W-1:0]   off_time,
    input  logic [BLANK_W-1:0] blank_cycles,
    input  logic [DT_W-1:0]    dead_cycles,
    output logic [IW-1:0]      thresh_out,
    output logic               gate_ah,
    output logic               gate_al,
    output logic               gate_bh,
    output logic               gate_bl
);
    logic   run;
    gates_t want;
    gates_t held;

    assign run = enable && (scale_code != CODE_OFF);

    hb_scale #(.IW(IW)) u_scale (
        .code       (scale_code),
        .full_scale (full_scale),
        .thresh     (thresh_out)
    );

    hb_phase_fsm #(.IW(IW), .OFF_W(OFF_W), .BLANK_W(BLANK_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .dir          (dir),
        .fast_sel     (fast_decay),
        .i_sense      (i_sense),
        .thresh       (thresh_out),
        .zero_level   (zero_level),
        .off_time     (off_time),
        .blank_cycles (blank_cycles),
        .want         (want)
    );

    hb_deadtime #(.DT_W(DT_W)) u_dead (
        .clk         (clk),
        .rst_n       (rst_n),
        .want        (want),
        .dead_cycles (dead_cycles),
        .gates       (held)
    );

    assign gate_ah = held.ah & run;
    assign gate_al = held.al & run;
    assign gate_bh = held.bh & run;
    assign gate_bl = held.bl & run;

endmodule

// File: rtl/hb_chopper_chk.sv
module hb_chopper_chk #(
    parameter int IW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [1:0]    scale_code,
    input logic [IW-1:0] full_scale,
    input logic [IW-1:0] thresh_out,
    input logic          gate_ah,
    input logic          gate_al,
    input logic          gate_bh,
    input logic          gate_bl
);
    p_thresh_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (scale_code == 2'b11) |-> (thresh_out == '0));

    p_thresh_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (scale_code == 2'b00) |-> (thresh_out == full_scale));

    p_force_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || scale_code == 2'b11) |-> !(gate_ah || gate_al || gate_bh || gate_bl));

    p_no_dual_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_ah && gate_bh));

    p_no_shoot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_ah && gate_al) && !(gate_bh && gate_bl));

    p_gap_al_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_al) |-> !$past(gate_ah));

    p_gap_ah_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_ah) |-> !$past(gate_al));

    p_gap_bl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_bl) |-> !$past(gate_bh));

    p_gap_bh_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_bh) |-> !$past(gate_bl));

endmodule

bind hbridge_chopper hb_chopper_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scale_code (scale_code),
    .full_scale (full_scale),
    .thresh_out (thresh_out),
    .gate_ah    (gate_ah),
    .gate_al    (gate_al),
    .gate_bh    (gate_bh),
    .gate_bl    (gate_bl)
);

// File: tb/hbridge_chopper_bench.sv
module hbridge_chopper_bench;
    localparam int IW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          dir = 1'b0;
    logic          fast_decay = 1'b0;
    logic [1:0]    scale_code = 2'b00;
    logic [IW-1:0] i_sense = '0;
    logic [IW-1:0] full_scale = 10'd400;
    logic [IW-1:0] zero_level = '0;
    logic [7:0]    off_time = 8'd5;
    logic [5:0]    blank_cycles = 6'd6;
    logic [3:0]    dead_cycles = 4'd2;
    logic [IW-1:0] thresh_out;
    logic          gate_ah, gate_al, gate_bh, gate_bl;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [3:0] pat;
        int         len;
        string      req;
    } item_t;

    item_t exp_q[$];
    logic       mon_on = 1'b0;
    logic       run_valid = 1'b0;
    logic [3:0] cur_pat;
    int         cur_len;

    always #4 clk = ~clk;

    hbridge_chopper u_hbridge_chopper (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dir(dir),
        .fast_decay(fast_decay), .scale_code(scale_code), .i_sense(i_sense),
        .full_scale(full_scale), .zero_level(zero_level), .off_time(off_time),
        .blank_cycles(blank_cycles), .dead_cycles(dead_cycles),
        .thresh_out(thresh_out), .gate_ah(gate_ah), .gate_al(gate_al),
        .gate_bh(gate_bh), .gate_bl(gate_bl)
    );

    function automatic logic [3:0] pat_now();
        return {gate_ah, gate_al, gate_bh, gate_bl};
    endfunction

    // monitor: measure runs of constant gate pattern and compare to queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (!run_valid) begin
                cur_pat   = pat_now();
                cur_len   = 1;
                run_valid = 1'b1;
            end else if (pat_now() == cur_pat) begin
                cur_len++;
            end else begin
                if (exp_q.size() > 0) begin
                    item_t it;
                    it = exp_q.pop_front();
                    checks++;
                    if (it.pat != cur_pat || (it.len != 0 && it.len != cur_len)) begin
                        fails++;
                        $display("FAIL %s: run pattern %b length %0d, expected %b length %0d",
                                 it.req, cur_pat, cur_len, it.pat, it.len);
                    end
                end
                cur_pat = pat_now();
                cur_len = 1;
            end
        end
    end

    task automatic push(input logic [3:0] p, input int n, input string req);
        item_t it;
        it.pat = p; it.len = n; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic check_val(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic start_run();
        @(negedge clk);
        rst_n     = 1'b0;
        mon_on    = 1'b0;
        run_valid = 1'b0;
        repeat (3) @(negedge clk);
        mon_on = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < 300 && exp_q.size() > 0; k++) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected runs never seen, expected 0", req, exp_q.size());
            exp_q.delete();
        end
        @(negedge clk);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // reset state
        repeat (2) @(negedge clk);
        check_val("R2 reset", int'(pat_now()), 0);

        // slow decay, dir=1, current held above threshold
        enable = 1'b1; dir = 1'b1; fast_decay = 1'b0; scale_code = 2'b00;
        i_sense = 10'd500; off_time = 8'd5; zero_level = '0;
        push(4'b0000, 0, "R10 start");
        push(4'b1001, 7, "R5 first drive");
        push(4'b0000, 3, "R10 drive-to-slow gap");
        push(4'b0101, 3, "R6 slow");
        push(4'b0000, 3, "R10 slow-to-drive gap");
        push(4'b1001, 4, "R9 redrive");
        push(4'b0000, 3, "R10 gap");
        push(4'b0101, 3, "R9 slow hold");
        start_run();
        drain("R9");

        // code 11 forces off in the same cycle; threshold decode
        @(negedge clk);
        scale_code = 2'b11; #1;
        check_val("R2 code 11", int'(pat_now()), 0);
        check_val("R1 code 11", int'(thresh_out), 0);
        scale_code = 2'b01; #1;
        check_val("R1 code 01", int'(thresh_out), 284);
        scale_code = 2'b10; #1;
        check_val("R1 code 10", int'(thresh_out), 151);
        scale_code = 2'b00; #1;
        check_val("R1 code 00", int'(thresh_out), 400);

        // fast decay, dir=0
        dir = 1'b0; fast_decay = 1'b1;
        push(4'b0000, 0, "R10 start");
        push(4'b0110, 7, "R3 drive dir0");
        push(4'b0000, 3, "R10 gap");
        push(4'b1001, 3, "R7 reverse");
        push(4'b0000, 3, "R10 gap");
        push(4'b0110, 4, "R5 redrive");
        push(4'b0000, 3, "R10 gap");
        push(4'b1001, 3, "R7 reverse again");
        start_run();
        drain("R7");

        // near-zero during fast reverse, dir=1, long off-time
        dir = 1'b1; off_time = 8'd9; zero_level = 10'd10; i_sense = 10'd500;
        push(4'b0000, 0, "R10 start");
        push(4'b1001, 7, "R3 drive dir1");
        push(4'b0000, 3, "R10 gap");
        push(4'b0110, 2, "R8 reverse cut short");
        push(4'b0000, 5, "R8 off until expiry");
        start_run();
        for (int k = 0; k < 200 && pat_now() != 4'b0110; k++) @(negedge clk);
        i_sense = 10'd5;
        drain("R8");

        // below threshold: no chop
        repeat (20) @(negedge clk);
        check_val("R4 low current holds drive", int'(pat_now()), 9);
        i_sense = 10'd300;
        repeat (20) @(negedge clk);
        check_val("R4 300 below 400 holds drive", int'(pat_now()), 9);
        scale_code = 2'b01;
        repeat (10) @(negedge clk);
        checks++;
        if (pat_now() == 4'b1001) begin
            fails++;
            $display("FAIL R4: pattern %b after 300 >= 284, expected a decay pattern", pat_now());
        end

        // enable low forces off at once
        enable = 1'b0; #1;
        check_val("R2 enable low", int'(pat_now()), 0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule